// File: doc/BRIEF.md
# DMA Channel Interrupt Enable and Pending Bank

This block collects completion events from the physical channels of a multi-channel DMA controller and presents them to software as two groups of memory-mapped registers: enable words and pending words. Every channel drives three single-cycle event pulses. The first marks that half of a transfer is done, the second marks that one descriptor is done, and the third marks that a whole descriptor list is done. A pending bit records its event only while the matching enable bit is set. One combined interrupt line is raised while any pending bit is set.

Each channel owns a 4-bit field, and eight fields share one 32-bit word, so two words cover up to 16 channels. Software acknowledges events by writing ones to the pending bits it wants to clear. Writing back the value it just read therefore acknowledges exactly the events it saw. The register port is a simple single-cycle write strobe, plus a read strobe whose data is registered. Unused addresses read as zero and ignore writes.

Top module: `dma_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, every enable and pending bit is 0, `irq_o` is 0 and `reg_rdata` is 0.
- R2: Channel n occupies bits (n mod 8)*4 .. (n mod 8)*4+3 of word n/8. Within a field, bit 0 is half-done, bit 1 is descriptor-done and bit 2 is list-done. Enable words sit at byte addresses 0x00 (channels 0-7) and 0x04 (channels 8-15). Pending words sit at 0x10 and 0x14. Address bits [1:0] are ignored.
- R3: A write to an enable word replaces bits 0-2 of every implemented field. Bit 3 of every field, and the fields of channels at or above NUM_CH, always read as 0.
- R4: An event pulse sets its pending bit at the next clock edge only if the enable bit held before that edge is 1. Several channels and event types may set bits in the same cycle.
- R5: Writing 1 to a pending bit clears it at that edge. Writing 0 leaves it unchanged, so writing back a value just read clears exactly those bits.
- R6: When an enabled event and a clear hit the same pending bit in the same cycle, the bit remains set.
- R7: `irq_o` is the OR of all pending bits, registered: it rises one cycle after the first pending bit sets and falls one cycle after the last one clears.
- R8: Clearing an enable bit does not clear a bit that is already pending, and events on disabled bits are ignored. With both enable words at zero, no event can set a pending bit.
- R9: Writes to enable words leave pending bits alone. Writes to any address other than 0x00, 0x04, 0x10 and 0x14 change nothing, and reads of those addresses return 0.
- R10: `reg_rdata` loads the addressed word at the edge where `reg_re` is 1 and holds its value in every cycle without `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_half | input | NUM_CH | Per-channel half-done pulse |
| ev_desc | input | NUM_CH | Per-channel descriptor-done pulse |
| ev_list | input | NUM_CH | Per-channel list-done pulse |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench runs with 12 channels, so that the upper word is partly unimplemented. It first writes all ones to the enable words. The read-back values show that bit 3 is dropped and that the missing channels read as zero. Single events are then placed on channels 0, 3, 9 and 11. Their pending positions pin down the word, lane and event-type layout, and a burst with every event on every channel shows which enable bits mask which events. Several further patterns separate distinct behaviours:
- clears of chosen bits, and writes of zero, show that clearing takes effect only on written ones;
- an event in the same cycle as a clear of that bit shows that the event wins;
- a write-back of the values just read shows that exactly those events are acknowledged;
- disabling the enables shows that bits already pending are kept while new events are blocked.

// File: rtl/dma_irq_pkg.sv
// Shared constants and types for the DMA interrupt enable/pending bank.
// Assumes byte addressing with 32-bit registers and at most two words per bank.
package dma_irq_pkg;
    localparam int FIELD_W     = 4;   // bits reserved per channel
    localparam int EVT_W       = 3;   // implemented event bits per channel
    localparam int WORD_W      = 32;
    localparam int CH_PER_WORD = WORD_W / FIELD_W;
    localparam int MAX_WORDS   = 2;
    localparam int EN_WIDX     = 0;   // word index (byte address / 4) of first enable word
    localparam int ST_WIDX     = 4;   // word index of first pending word

    // Event bit order inside a field: [0] half, [1] descriptor, [2] list
    typedef logic [EVT_W-1:0] evt_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_ST   = 2'd2
    } sel_e;
endpackage

// File: rtl/dma_irq_decode.sv
// Address decoder: maps a byte address to a bank (enable, pending or none)
// and a word index inside the bank. Assumes ADDR_W >= 5; bits [1:0] ignored.
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic              word
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             unused_lo;

    assign widx      = addr[ADDR_W-1:2];
    assign unused_lo = ^addr[1:0];

    // Purpose: classify the word index into a bank and a word within it
    always_comb begin
        sel  = SEL_NONE;
        word = widx[0];
        if (widx == IDX_W'(EN_WIDX) || widx == IDX_W'(EN_WIDX + 1)) begin
            sel = SEL_EN;
        end else if (widx == IDX_W'(ST_WIDX) || widx == IDX_W'(ST_WIDX + 1)) begin
            sel = SEL_ST;
        end
    end
endmodule

// File: rtl/dma_irq_cell.sv
// One channel's enable and pending state. Pending bits set on an event
// when the stored enable is 1 and clear on a write-one; set wins over clear.
module dma_irq_cell
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t ev,
    input  logic en_we,
    input  evt_t en_wdata,
    input  logic st_we,
    input  evt_t st_wdata,
    output evt_t en_q,
    output evt_t pend_q
);
    evt_t clr_mask;

    assign clr_mask = st_we ? st_wdata : '0;

    // Purpose: hold the channel's enable bits, replaced on an enable write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= en_wdata;
        end
    end

    // Purpose: latch enabled events and apply write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | (ev & en_q);
        end
    end
endmodule

// File: rtl/dma_irq_rdmux.sv
// Assembles the register words from the per-channel state and returns the
// addressed word through a register loaded only on a read strobe.
// Assumes NUM_CH <= MAX_WORDS * CH_PER_WORD.
module dma_irq_rdmux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  sel_e                         sel,
    input  logic                         word,
    input  logic [NUM_CH-1:0][EVT_W-1:0] en_vec,
    input  logic [NUM_CH-1:0][EVT_W-1:0] pend_vec,
    output logic [WORD_W-1:0]            rdata
);
    logic [MAX_WORDS-1:0][WORD_W-1:0] en_word;
    logic [MAX_WORDS-1:0][WORD_W-1:0] st_word;
    logic [WORD_W-1:0]                rd_mux;

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        for (genvar l = 0; l < CH_PER_WORD; l++) begin : g_lane
            localparam int CH = w * CH_PER_WORD + l;
            if (CH < NUM_CH) begin : g_impl
                assign en_word[w][l*FIELD_W +: FIELD_W] = {1'b0, en_vec[CH]};
                assign st_word[w][l*FIELD_W +: FIELD_W] = {1'b0, pend_vec[CH]};
            end else begin : g_absent
                assign en_word[w][l*FIELD_W +: FIELD_W] = '0;
                assign st_word[w][l*FIELD_W +: FIELD_W] = '0;
            end
        end
    end

    // Purpose: select the addressed word, zero for undecoded addresses
    always_comb begin
        case (sel)
            SEL_EN:  rd_mux = en_word[word];
            SEL_ST:  rd_mux = st_word[word];
            default: rd_mux = '0;
        endcase
    end

    // Purpose: register read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/dma_irq_bank.sv
// Interrupt enable/pending bank for up to 16 DMA channels. Each channel
// has a 4-bit field (half, descriptor, list, spare); eight fields per word.
// Enable words at 0x00/0x04, pending words at 0x10/0x14, write-one-to-clear.
// irq_o is the registered OR of all pending bits.
module dma_irq_bank
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_half,
    input  logic [NUM_CH-1:0] ev_desc,
    input  logic [NUM_CH-1:0] ev_list,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              reg_re,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_o
);
    sel_e                         sel;
    logic                         word;
    logic [NUM_CH-1:0][EVT_W-1:0] en_vec;
    logic [NUM_CH-1:0][EVT_W-1:0] pend_vec;
    logic                         unused_wdata;

    assign unused_wdata = ^reg_wdata;

    dma_irq_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (reg_addr),
        .sel  (sel),
        .word (word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int W    = c / CH_PER_WORD;
        localparam int LANE = c % CH_PER_WORD;

        logic hit;
        assign hit = (word == 1'(W));

        dma_irq_cell cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       ({ev_list[c], ev_desc[c], ev_half[c]}),
            .en_we    (reg_we && sel == SEL_EN && hit),
            .en_wdata (reg_wdata[LANE*FIELD_W +: EVT_W]),
            .st_we    (reg_we && sel == SEL_ST && hit),
            .st_wdata (reg_wdata[LANE*FIELD_W +: EVT_W]),
            .en_q     (en_vec[c]),
            .pend_q   (pend_vec[c])
        );
    end

    dma_irq_rdmux #(.NUM_CH(NUM_CH)) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (reg_re),
        .sel      (sel),
        .word     (word),
        .en_vec   (en_vec),
        .pend_vec (pend_vec),
        .rdata    (reg_rdata)
    );

    // Purpose: register the combined interrupt from all pending bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |pend_vec;
        end
    end
endmodule

// File: rtl/dma_irq_bank_chk.sv
// Property checker for dma_irq_bank, attached by bind. Decodes clear writes
// independently from the register port to judge the pending bits.
module dma_irq_bank_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            ev_half,
    input logic [NUM_CH-1:0]            ev_desc,
    input logic [NUM_CH-1:0]            ev_list,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic                         reg_we,
    input logic [WORD_W-1:0]            reg_wdata,
    input logic                         reg_re,
    input logic [WORD_W-1:0]            reg_rdata,
    input logic                         irq_o,
    input logic [NUM_CH-1:0][EVT_W-1:0] en_vec,
    input logic [NUM_CH-1:0][EVT_W-1:0] pend_vec
);
    localparam int IDX_W = ADDR_W - 2;

    logic armed;

    // Purpose: mark cycles where the previous sample was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7
    irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        irq_o == (|$past(pend_vec)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        localparam int W    = c / CH_PER_WORD;
        localparam int LANE = c % CH_PER_WORD;
        logic [EVT_W-1:0] evb;
        assign evb = {ev_list[c], ev_desc[c], ev_half[c]};
        for (genvar b = 0; b < EVT_W; b++) begin : g_b
            logic clr_hit;
            assign clr_hit = reg_we && (reg_addr[ADDR_W-1:2] == IDX_W'(ST_WIDX + W))
                             && reg_wdata[LANE*FIELD_W + b];

            // R4 R8
            masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!en_vec[c][b] && !pend_vec[c][b]) |=> !pend_vec[c][b]);

            // R4 R6
            event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (evb[b] && en_vec[c][b]) |=> pend_vec[c][b]);

            // R5
            pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_vec[c][b] && !clr_hit) |=> pend_vec[c][b]);
        end
    end
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_half   (ev_half),
    .ev_desc   (ev_desc),
    .ev_list   (ev_list),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec)
);

// File: tb/dma_irq_bank_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them when the registered read data appears.
module dma_irq_bank_tb_top;
    localparam int NCH    = 12;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ev_half = '0, ev_desc = '0, ev_list = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0, reg_re = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_o;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        re_d = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_bank #(.NUM_CH(NCH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_half(ev_half), .ev_desc(ev_desc),
        .ev_list(ev_list), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare registered read data the cycle after a read strobe
    always @(posedge clk) re_d <= reg_re;
    always @(negedge clk) begin
        if (re_d && exp_q.size() > 0) begin
            chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // One cycle of register and event stimulus, starting at a falling edge
    task automatic step(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                        input logic [15:0] h, input logic [15:0] d, input logic [15:0] l);
        reg_we = we; reg_addr = addr; reg_wdata = wd;
        ev_half = h[NCH-1:0]; ev_desc = d[NCH-1:0]; ev_list = l[NCH-1:0];
        @(negedge clk);
        reg_we = 1'b0; ev_half = '0; ev_desc = '0; ev_list = '0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
        step(1'b1, addr, wd, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_re = 1'b1; reg_addr = addr;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1 reset state
        chk({31'b0, irq_o}, 32'h0, "R1 irq after reset");
        chk(reg_rdata, 32'h0, "R1 rdata after reset");
        rd(8'h00, 32'h0, "R1 enable0 reset");
        rd(8'h10, 32'h0, "R1 pending0 reset");
        rd(8'h14, 32'h0, "R1 pending1 reset");

        // R3 enable write and read back, spare bits and absent channels read zero
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h7777_7777, "R3 enable0 readback");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0000_7777, "R3 enable1 absent channels");

        // R9 undecoded address
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R9 undecoded read");
        rd(8'h10, 32'h0, "R9 no pending from enable writes");
        rd(8'h00, 32'h7777_7777, "R9 enable0 unchanged by stray write");

        // R2 R4 R7 half event on channel 3
        step(1'b0, 8'h0, 32'h0, 16'h0008, 16'h0, 16'h0);
        chk({31'b0, irq_o}, 32'h0, "R7 irq not yet set");
        idle(1);
        chk({31'b0, irq_o}, 32'h1, "R7 irq set one cycle later");
        rd(8'h10, 32'h0000_1000, "R2 channel3 half");

        // R2 list event on channel 9, descriptor on 0, half on 11
        step(1'b0, 8'h0, 32'h0, 16'h0, 16'h0, 16'h0200);
        rd(8'h14, 32'h0000_0040, "R2 channel9 list");
        step(1'b0, 8'h0, 32'h0, 16'h0800, 16'h0001, 16'h0);
        rd(8'h10, 32'h0000_1002, "R2 R4 channel0 desc");
        rd(8'h14, 32'h0000_1040, "R4 channel11 half");

        // R5 write-one clears, write-zero keeps (byte addr bit 1 ignored: 0x12)
        wr(8'h10, 32'h0000_1000);
        rd(8'h10, 32'h0000_0002, "R5 clear channel3");
        wr(8'h12, 32'h0000_0000);
        rd(8'h10, 32'h0000_0002, "R5 zero write keeps");

        // R8 R9 disable keeps pending, blocks new events
        wr(8'h00, 32'h0);
        rd(8'h10, 32'h0000_0002, "R9 enable write keeps pending");
        step(1'b0, 8'h0, 32'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        rd(8'h10, 32'h0000_0002, "R8 masked events ignored");
        rd(8'h14, 32'h0000_7777, "R4 all enabled events upper word");
        idle(3);
        chk(reg_rdata, 32'h0000_7777, "R10 rdata holds without read");

        // R6 set wins over clear
        wr(8'h00, 32'hFFFF_FFFF);
        step(1'b0, 8'h0, 32'h0, 16'h0020, 16'h0, 16'h0);
        rd(8'h10, 32'h0010_0002, "R4 channel5 half");
        step(1'b1, 8'h10, 32'h0010_0000, 16'h0020, 16'h0, 16'h0);
        rd(8'h10, 32'h0010_0002, "R6 set wins over clear");

        // R5 R7 write back acknowledges exactly what was read
        wr(8'h10, 32'h0010_0002);
        wr(8'h14, 32'h0000_7777);
        chk({31'b0, irq_o}, 32'h1, "R7 irq still high one cycle");
        idle(1);
        chk({31'b0, irq_o}, 32'h0, "R7 irq drops after clear");
        rd(8'h10, 32'h0, "R5 pending0 acknowledged");
        rd(8'h14, 32'h0, "R5 pending1 acknowledged");

        // R8 both enables zero masks every source
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        step(1'b0, 8'h0, 32'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        idle(1);
        chk({31'b0, irq_o}, 32'h0, "R8 irq stays low when masked");
        rd(8'h10, 32'h0, "R8 pending0 masked");
        rd(8'h14, 32'h0, "R8 pending1 masked");

        idle(3);
        if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'h0, "scoreboard drained");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule